// File: doc/BRIEF.md
# Grouped Timer Tick Generator

This block produces the count-enable pulses for five timer channels from a single peripheral clock. Two 8-bit prescalers divide the peripheral clock; the first serves timers 0 and 1, the second serves timers 2, 3 and 4. Each timer then applies its own power-of-two post-divider, or it takes its pulses from the external clock input of its group instead.

One 4-bit field per timer holds both choices. Its low values pick the divide ratio. Its high values pick the external source, and in that case they replace the divider setting. Every output is a single-cycle enable pulse in the peripheral clock domain, so the timer counters that use it stay on one clock. The external inputs are asynchronous. They pass through a two-flop synchronizer and a rising-edge detector before they become pulses. If software writes a new value to a prescaler, that prescaler and the post-dividers of its group start again from zero, so the new rate takes effect with a known phase.

Top module: `tmr_tick_tree`

## Requirements
- R1: While rst_ni is low, every bit of tick_o is 0.
- R2: A prescaler programmed with value p issues one pulse every p+1 peripheral clock cycles. Value 0 gives a pulse every cycle.
- R3: A timer field value n in 0..3 (bits [4t+3:4t] of tmr_sel_i for timer t) selects a post-divider of 1 << (n+1), which is 2, 4, 8 or 16. Such a timer pulses once every (p+1) * (1 << (n+1)) cycles.
- R4: Prescaler 0 (pre_val_i[7:0]) drives timers 0 and 1. Prescaler 1 (pre_val_i[15:8]) drives timers 2, 3 and 4.
- R5: A timer field value from 4 to 15 selects the external source. Timers 0-1 use ext_clk_i[0] and timers 2-4 use ext_clk_i[1]. Each rising edge of that input, driven before a clock edge, gives one tick_o pulse that is visible after the third rising clock edge.
- R6: A timer on the external source gives no pulse from its prescaler path, and no pulse from the external input of the other group.
- R7: A change of a prescaler value restarts that group. With the new value p applied before clock edge E0 and timer field n, the timer's first pulse is visible after edge E0 + (p+1)*(1 << (n+1)).
- R8: With its field unchanged, a timer never pulses in two consecutive cycles.
- R9: A timer in divider mode ignores its external clock input. Its pulse period stays as R3 gives while that input toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_val_i | input | 16 | Prescaler values; group 0 in [7:0], group 1 in [15:8] |
| tmr_sel_i | input | 20 | Per-timer 4-bit select fields, timer t in [4t+3:4t] |
| ext_clk_i | input | 2 | Asynchronous external clocks for group 0 and group 1 |
| tick_o | output | 5 | Single-cycle count-enable pulse for each timer |

## Verification
A divider-mode pulse leaves a registered output one edge after the post-divider match. Because of this, steady-state periods are measured from one pulse to the next, and the latency does not enter those checks. After a prescaler write, the first pulse is due exactly (p+1)*div edges after the first edge that sees the new value. The bench counts edges from a change driven at a falling edge and expects the pulse on the sample after edge (p+1)*div+1. An external rising edge passes through two synchronizer flops, the edge register and the output register, so the bench expects the pulse on the third sample and checks the other timers on that same sample. All sampling happens at falling edges.

// File: rtl/tmr_tick_pkg.sv
`timescale 1ns/1ps
package tmr_tick_pkg;
  localparam int SEL_W = 4;

  // field values >= 4 route the external clock
  function automatic logic sel_is_ext(input logic [SEL_W-1:0] f);
    return |f[SEL_W-1:2];
  endfunction

  // low field bits n -> mask of (1 << (n+1)) - 1
  function automatic logic [3:0] div_mask(input logic [1:0] n);
    logic [4:0] one_hot;
    one_hot = 5'd2 << n;
    return 4'(one_hot - 5'd1);
  endfunction
endpackage

// File: rtl/tmr_tick_prescaler.sv
`timescale 1ns/1ps
module tmr_tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] val_i,
  output logic             tick_o,
  output logic             restart_o
);
  logic [PRE_W-1:0] val_q, cnt_q;

  assign restart_o = (val_i != val_q);
  assign tick_o    = !restart_o && (cnt_q == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (restart_o) begin
      val_q <= val_i;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_restart_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> (cnt_q == '0 && val_q == $past(val_i)));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_o && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && val_q != '0) |=> !tick_o);
endmodule

// File: rtl/tmr_tick_postdiv.sv
`timescale 1ns/1ps
module tmr_tick_postdiv
  import tmr_tick_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_tick_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] field_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, mask;

  assign mask   = CNT_W'(div_mask(field_i[1:0]));
  assign tick_o = pre_tick_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (pre_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  p_hold_without_pre_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_tick_i && !restart_i) |=> $stable(cnt_q));

  p_no_back_to_back_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $stable(field_i)) |=> !tick_o);
endmodule

// File: rtl/tmr_tick_ext_sync.sv
`timescale 1ns/1ps
module tmr_tick_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_i};
  end

  assign rise_o = sync_q[1] && !sync_q[2];

  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_tick_tree.sv
`timescale 1ns/1ps
module tmr_tick_tree
  import tmr_tick_pkg::*;
#(
  parameter int NUM_TMR   = 5,
  parameter int PRE_W     = 8,
  parameter int GRP0_TMRS = 2,
  parameter int DIV_CNT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2*PRE_W-1:0]       pre_val_i,
  input  logic [NUM_TMR*SEL_W-1:0] tmr_sel_i,
  input  logic [1:0]               ext_clk_i,
  output logic [NUM_TMR-1:0]       tick_o
);
  localparam int NUM_GRP = 2;

  logic [NUM_GRP-1:0] pre_tick, pre_restart, ext_rise;
  logic [NUM_TMR-1:0] div_tick, ext_sel, tick_d;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tmr_tick_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .val_i    (pre_val_i[g*PRE_W +: PRE_W]),
      .tick_o   (pre_tick[g]),
      .restart_o(pre_restart[g])
    );
    tmr_tick_ext_sync i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ext_i (ext_clk_i[g]),
      .rise_o(ext_rise[g])
    );
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int GRP = (t < GRP0_TMRS) ? 0 : 1;
    logic [SEL_W-1:0] field;
    assign field      = tmr_sel_i[t*SEL_W +: SEL_W];
    assign ext_sel[t] = sel_is_ext(field);

    tmr_tick_postdiv #(.CNT_W(DIV_CNT_W)) i_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pre_tick_i(pre_tick[GRP]),
      .restart_i (pre_restart[GRP]),
      .field_i   (field),
      .tick_o    (div_tick[t])
    );

    assign tick_d[t] = ext_sel[t] ? ext_rise[GRP] : div_tick[t];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_o[t] <= 1'b0;
      else         tick_o[t] <= tick_d[t];
    end

    p_ext_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ext_sel[t]) && tick_o[t]) |-> $past(ext_rise[GRP]));

    p_ext_blocks_pre_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ext_sel[t]) && !$past(ext_rise[GRP])) |-> !tick_o[t]);

    p_div_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(ext_sel[t]) && tick_o[t]) |-> $past(pre_tick[GRP]));

    p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o[t] && $stable(tmr_sel_i)) |=> !tick_o[t]);
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (tick_o == '0));
endmodule

// File: tb/test_tmr_tick_tree.sv
`timescale 1ns/1ps
module test_tmr_tick_tree;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pre_val = '0;
  logic [19:0] tmr_sel = '0;
  logic [1:0]  ext_clk = '0;
  logic [4:0]  tick;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr_tick_tree i_tmr_tick_tree (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pre_val_i(pre_val),
    .tmr_sel_i(tmr_sel),
    .ext_clk_i(ext_clk),
    .tick_o   (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_field(input int t, input logic [3:0] v);
    tmr_sel[t*4 +: 4] = v;
  endtask

  task automatic gap_of(input int t, output int g);
    int w = 0;
    do begin @(negedge clk); w++; end while (!tick[t] && w < 3000);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick[t] && g < 3000);
  endtask

  int pre0_tab[4] = '{0, 1, 3, 6};
  int pre1_tab[4] = '{2, 0, 5, 1};

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g, n, p, e;
    // R1: reset holds outputs low
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(tick == '0, "R1 reset", int'(tick), 0);
    end
    rst_n = 1'b1;

    // R2 R3 R4: sweep prescalers and divider codes
    for (int pi = 0; pi < 4; pi++) begin
      for (int d = 0; d < 4; d++) begin
        @(negedge clk);
        pre_val = {8'(pre1_tab[pi]), 8'(pre0_tab[pi])};
        for (int t = 0; t < 5; t++) set_field(t, 4'((d + t) % 4));
        for (int t = 0; t < 5; t++) begin
          p = (t < 2) ? pre0_tab[pi] : pre1_tab[pi];
          e = (p + 1) * (2 << ((d + t) % 4));
          gap_of(t, g);
          chk(g == e, "R2 R3 R4 period", g, e);
        end
      end
    end

    // R7: restart after prescaler write
    @(negedge clk);
    pre_val = {8'd3, 8'd2};
    tmr_sel = '0;
    set_field(1, 4'd2);
    repeat (60) @(negedge clk);
    pre_val[7:0] = 8'd4;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[0] && n < 200);
    chk(n == 11, "R7 restart timer0", n, 11);
    pre_val[7:0] = 8'd1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[1] && n < 200);
    chk(n == 17, "R7 restart timer1", n, 17);

    // R5 R6: external source
    @(negedge clk);
    pre_val = {8'd0, 8'd0};
    set_field(0, 4'd4); set_field(1, 4'd9); set_field(2, 4'd4);
    set_field(3, 4'd0); set_field(4, 4'd15);
    repeat (5) @(negedge clk);
    e = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if ((tick & 5'b10111) != '0) e++;
    end
    chk(e == 0, "R6 ext mode ignores prescaler", e, 0);

    ext_clk[0] = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[0] && n < 20);
    chk(n == 3, "R5 ext0 latency", n, 3);
    chk(tick[1] == 1'b1, "R5 timer1 on ext0", int'(tick[1]), 1);
    chk(tick[2] == 1'b0 && tick[4] == 1'b0, "R6 group1 ignores ext0",
        int'({tick[4], tick[2]}), 0);
    @(negedge clk);
    chk(tick[0] == 1'b0, "R8 ext pulse width", int'(tick[0]), 0);
    e = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick[0]) e++;
    end
    chk(e == 0, "R5 one pulse per edge", e, 0);

    ext_clk[1] = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[2] && n < 20);
    chk(n == 3, "R5 ext1 latency", n, 3);
    chk(tick[4] == 1'b1, "R5 timer4 on ext1", int'(tick[4]), 1);
    chk(tick[0] == 1'b0 && tick[1] == 1'b0, "R6 group0 ignores ext1",
        int'(tick[1:0]), 0);

    // R9: divider mode ignores toggling external input
    @(negedge clk);
    pre_val = {8'd2, 8'd1};
    tmr_sel = '0;
    set_field(0, 4'd1);
    set_field(3, 4'd0);
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          repeat (3) @(negedge clk);
          ext_clk = ~ext_clk;
        end
      end
      begin
        for (int k = 0; k < 3; k++) begin
          gap_of(0, g);
          chk(g == 8, "R9 timer0 with ext toggling", g, 8);
        end
        gap_of(3, g);
        chk(g == 6, "R9 timer3 with ext toggling", g, 6);
      end
    join

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule